// File: doc/BRIEF.md
# Privileged Trap Entry Unit

This block carries out the architectural state change that happens when a hart takes a trap. A trap request carries an interrupt flag, a cause code, a source kind and a faulting address. The unit also samples the current program counter, privilege level, interrupt-enable status bits, both delegation masks and both trap-vector registers. From these it picks the handling level, supervisor or machine. It then produces the new status bits, the cause word, the exception PC, the trap value and the new PC, and it switches privilege.

The cause code can be given directly, or derived inside the unit. For a misaligned access it is taken from the access kind. For a failed address translation it depends on whether translation was enabled and whether the failure came from a protection check. A direct environment-call cause is rewritten according to the privilege at which the call was made. All results are registered and valid for one cycle after the request.

A small state machine marks each result. Its states are `ST_IDLE` (no result), `ST_ENTER_S` (a supervisor-level entry was just committed) and `ST_ENTER_M` (a machine-level entry was just committed). Any state moves to `ST_ENTER_S` or `ST_ENTER_M` when a request is sampled, chosen by the routing decision. Any state moves to `ST_IDLE` when no request is sampled.

Top module: `trap_entry_unit`

## Requirements
- R1: A request sampled at a rising edge gives `trap_valid` high in the following cycle, and `trap_to_m` tells which level took it. A cycle with no request sampled gives `trap_valid` low in the next cycle, so back-to-back requests keep it high.
- R2: The delegation mask is `ideleg` for interrupts and `edeleg` for exceptions, indexed by the final cause code. The trap goes to supervisor level (`trap_to_m`=0) only when `cur_priv` is 0 (user) or 1 (supervisor), the indexed bit is 1 and the cause is below XLEN. Otherwise it goes to machine level (`cur_priv` value 3; value 2 counts as above supervisor).
- R3: On supervisor entry: `out_spie` takes `cur_sie`, `out_spp` is 1 exactly when `cur_priv` was 1, `out_sie` is 0, `new_priv` is 1, and the three machine-level fields pass through unchanged.
- R4: On machine entry: `out_mpie` takes `cur_mie`, `out_mpp` takes `cur_priv`, `out_mie` is 0, `new_priv` is 3, and the three supervisor-level fields pass through unchanged.
- R5: `cause_out` holds the final cause code, zero-extended, with bit XLEN-1 set to 1 for interrupts. `epc_out` holds `cur_pc`.
- R6: `tval_out` holds `req_addr` only for exceptions whose final cause is 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other exception and for every interrupt it is 0.
- R7: An exception with `req_src`=0 (direct) and `req_cause`=8 is reported as cause 8 + `cur_priv`, giving 8, 9 and 11 for user, supervisor and machine.
- R8: `new_pc` is the chosen level's vector register (`stvec` or `mtvec`) with bits [1:0] cleared. When those bits equal 1 and the trap is an interrupt, 4 times the cause is added. Mode values 0, 2 and 3 add nothing.
- R9: An exception with `req_src`=1 (misaligned) gets cause 0, 4 or 6 for `req_acc` 0 (fetch), 1 (load) or 2/3 (store).
- R10: An exception with `req_src`=2 (translation failure) gets a page-fault cause (12, 13, 15 for fetch, load, store) when `xlate_on`=1 and `req_prot_fail`=0. Otherwise it gets an access-fault cause (1, 5, 7). For interrupts `req_src` is ignored.
- R11: During and right after reset, `trap_valid` and `lr_clear` are 0, `new_priv` is 3, and every other output is 0.
- R12: `lr_clear` is high together with `trap_valid` exactly when the new privilege differs from the `cur_priv` sampled with the request. It is never high without `trap_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_req | input | 1 | Take a trap at this edge |
| req_intr | input | 1 | 1 = interrupt, 0 = exception |
| req_src | input | 2 | 0 direct, 1 misaligned, 2 translation failure, 3 direct |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2/3 store |
| req_prot_fail | input | 1 | Translation failure came from a protection check |
| xlate_on | input | 1 | Address translation enabled |
| req_cause | input | CAUSE_W | Cause code for direct requests and interrupts |
| req_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_sie | input | 1 | Supervisor interrupt enable |
| cur_spie | input | 1 | Supervisor previous interrupt enable |
| cur_spp | input | 1 | Supervisor previous privilege |
| cur_mie | input | 1 | Machine interrupt enable |
| cur_mpie | input | 1 | Machine previous interrupt enable |
| cur_mpp | input | 2 | Machine previous privilege |
| ideleg | input | XLEN | Interrupt delegation mask |
| edeleg | input | XLEN | Exception delegation mask |
| stvec | input | XLEN | Supervisor trap vector (base and mode) |
| mtvec | input | XLEN | Machine trap vector (base and mode) |
| trap_valid | output | 1 | Results below belong to a trap just taken |
| trap_to_m | output | 1 | 1 = machine level, 0 = supervisor level |
| new_priv | output | 2 | Privilege after the trap |
| new_pc | output | XLEN | Handler address |
| cause_out | output | XLEN | Cause word |
| epc_out | output | XLEN | Exception PC |
| tval_out | output | XLEN | Trap value |
| out_sie | output | 1 | New supervisor interrupt enable |
| out_spie | output | 1 | New supervisor previous interrupt enable |
| out_spp | output | 1 | New supervisor previous privilege |
| out_mie | output | 1 | New machine interrupt enable |
| out_mpie | output | 1 | New machine previous interrupt enable |
| out_mpp | output | 2 | New machine previous privilege |
| lr_clear | output | 1 | Drop the load reservation |

## Verification
The bench looks for mistakes in routing. It sends machine-level traps whose delegation bit is set, and an interrupt cause of 40, which is beyond the mask width. A design that ignores privilege or indexes the mask out of range would send these to the supervisor. It checks that interrupts and exceptions with the same cause number are routed by different masks, which catches a design that uses one mask for both. It checks the vector offset for interrupts against exceptions and against modes 2 and 3; a wrong design would add the offset to every trap or to the wrong mode. It also checks the ecall rewrite at every privilege, the split between page faults and access faults when translation is off or a protection check failed, the trap value for address and non-address causes, and status save with the enables both set and cleared. A design that swaps the previous-enable and enable fields, or leaves the other level's fields disturbed, fails those checks.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } level_e;

    typedef enum logic [1:0] {
        SRC_DIRECT   = 2'd0,
        SRC_MISALIGN = 2'd1,
        SRC_XLATE    = 2'd2,
        SRC_DIRECT2  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ENTER_S = 2'd1,
        ST_ENTER_M = 2'd2
    } entry_state_e;

    localparam int CODE_MIS_FETCH  = 0;
    localparam int CODE_ACC_FETCH  = 1;
    localparam int CODE_MIS_LOAD   = 4;
    localparam int CODE_ACC_LOAD   = 5;
    localparam int CODE_MIS_STORE  = 6;
    localparam int CODE_ACC_STORE  = 7;
    localparam int CODE_ECALL_BASE = 8;
    localparam int CODE_PF_FETCH   = 12;
    localparam int CODE_PF_LOAD    = 13;
    localparam int CODE_PF_STORE   = 15;

endpackage

// File: rtl/trap_cause_map.sv
module trap_cause_map
    import trap_entry_pkg::*;
#(
    parameter int CAUSE_W = 6
) (
    input  logic               is_intr,
    input  logic [1:0]         src,
    input  logic [1:0]         acc,
    input  logic               prot_fail,
    input  logic               xlate_en,
    input  logic [CAUSE_W-1:0] raw_code,
    input  logic [1:0]         level,
    output logic [CAUSE_W-1:0] final_code,
    output logic               keeps_addr
);

    logic [CAUSE_W-1:0] mis_code;
    logic [CAUSE_W-1:0] xl_code;
    logic               page_fault;

    always_comb begin
        unique case (acc)
            2'd0:    mis_code = CAUSE_W'(CODE_MIS_FETCH);
            2'd1:    mis_code = CAUSE_W'(CODE_MIS_LOAD);
            default: mis_code = CAUSE_W'(CODE_MIS_STORE);
        endcase
    end

    assign page_fault = xlate_en && !prot_fail;

    always_comb begin
        unique case (acc)
            2'd0:    xl_code = page_fault ? CAUSE_W'(CODE_PF_FETCH) : CAUSE_W'(CODE_ACC_FETCH);
            2'd1:    xl_code = page_fault ? CAUSE_W'(CODE_PF_LOAD)  : CAUSE_W'(CODE_ACC_LOAD);
            default: xl_code = page_fault ? CAUSE_W'(CODE_PF_STORE) : CAUSE_W'(CODE_ACC_STORE);
        endcase
    end

    always_comb begin
        final_code = raw_code;
        if (!is_intr) begin
            unique case (src_e'(src))
                SRC_MISALIGN: final_code = mis_code;
                SRC_XLATE:    final_code = xl_code;
                default: begin
                    if (raw_code == CAUSE_W'(CODE_ECALL_BASE))
                        final_code = CAUSE_W'(CODE_ECALL_BASE) + CAUSE_W'(level);
                end
            endcase
        end
    end

    always_comb begin
        keeps_addr = 1'b0;
        if (!is_intr) begin
            unique case (int'(final_code))
                CODE_MIS_FETCH, CODE_ACC_FETCH, CODE_MIS_LOAD, CODE_ACC_LOAD,
                CODE_MIS_STORE, CODE_ACC_STORE, CODE_PF_FETCH, CODE_PF_LOAD,
                CODE_PF_STORE: keeps_addr = 1'b1;
                default:       keeps_addr = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               is_intr,
    input  logic [CAUSE_W-1:0] code,
    input  logic [1:0]         level,
    input  logic [XLEN-1:0]    int_mask,
    input  logic [XLEN-1:0]    exc_mask,
    output logic               go_super
);

    logic [XLEN-1:0] mask_sel;
    logic [XLEN-1:0] shifted;
    logic            in_range;
    logic            low_level;

    assign mask_sel  = is_intr ? int_mask : exc_mask;
    assign shifted   = mask_sel >> code;
    assign in_range  = int'(code) < XLEN;
    assign low_level = (level == LVL_USER) || (level == LVL_SUPER);
    assign go_super  = low_level && in_range && shifted[0];

endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic [XLEN-1:0]    vec_reg,
    input  logic               is_intr,
    input  logic [CAUSE_W-1:0] code,
    output logic [XLEN-1:0]    target
);

    localparam logic [1:0] MODE_VECTORED = 2'd1;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    assign base   = {vec_reg[XLEN-1:2], 2'b00};
    assign offset = (is_intr && vec_reg[1:0] == MODE_VECTORED) ? (XLEN'(code) << 2) : '0;
    assign target = base + offset;

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req,
    input  logic               req_intr,
    input  logic [1:0]         req_src,
    input  logic [1:0]         req_acc,
    input  logic               req_prot_fail,
    input  logic               xlate_on,
    input  logic [CAUSE_W-1:0] req_cause,
    input  logic [XLEN-1:0]    req_addr,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [1:0]         cur_priv,
    input  logic               cur_sie,
    input  logic               cur_spie,
    input  logic               cur_spp,
    input  logic               cur_mie,
    input  logic               cur_mpie,
    input  logic [1:0]         cur_mpp,
    input  logic [XLEN-1:0]    ideleg,
    input  logic [XLEN-1:0]    edeleg,
    input  logic [XLEN-1:0]    stvec,
    input  logic [XLEN-1:0]    mtvec,
    output logic               trap_valid,
    output logic               trap_to_m,
    output logic [1:0]         new_priv,
    output logic [XLEN-1:0]    new_pc,
    output logic [XLEN-1:0]    cause_out,
    output logic [XLEN-1:0]    epc_out,
    output logic [XLEN-1:0]    tval_out,
    output logic               out_sie,
    output logic               out_spie,
    output logic               out_spp,
    output logic               out_mie,
    output logic               out_mpie,
    output logic [1:0]         out_mpp,
    output logic               lr_clear
);

    localparam int N_DEST  = 2;
    localparam int PAD_W   = XLEN - 1 - CAUSE_W;

    entry_state_e       state_q, state_d;
    logic [CAUSE_W-1:0] code;
    logic               keeps_addr;
    logic               go_super;
    logic [1:0]         dest_level;
    logic [XLEN-1:0]    vec_regs  [N_DEST];
    logic [XLEN-1:0]    vec_tgt   [N_DEST];

    logic [1:0]         priv_q;
    logic [XLEN-1:0]    pc_q, cause_q, epc_q, tval_q;
    logic               sie_q, spie_q, spp_q, mie_q, mpie_q, lr_q;
    logic [1:0]         mpp_q;

    trap_cause_map #(.CAUSE_W(CAUSE_W)) map_i (
        .is_intr    (req_intr),
        .src        (req_src),
        .acc        (req_acc),
        .prot_fail  (req_prot_fail),
        .xlate_en   (xlate_on),
        .raw_code   (req_cause),
        .level      (cur_priv),
        .final_code (code),
        .keeps_addr (keeps_addr)
    );

    trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) route_i (
        .is_intr  (req_intr),
        .code     (code),
        .level    (cur_priv),
        .int_mask (ideleg),
        .exc_mask (edeleg),
        .go_super (go_super)
    );

    assign vec_regs[0] = stvec;
    assign vec_regs[1] = mtvec;

    for (genvar d = 0; d < N_DEST; d++) begin : g_vec
        trap_vector_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) calc_i (
            .vec_reg (vec_regs[d]),
            .is_intr (req_intr),
            .code    (code),
            .target  (vec_tgt[d])
        );
    end

    assign dest_level = go_super ? LVL_SUPER : LVL_MACH;

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        if (trap_req)
            state_d = go_super ? ST_ENTER_S : ST_ENTER_M;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            priv_q  <= LVL_MACH;
            pc_q    <= '0;
            cause_q <= '0;
            epc_q   <= '0;
            tval_q  <= '0;
            sie_q   <= 1'b0;
            spie_q  <= 1'b0;
            spp_q   <= 1'b0;
            mie_q   <= 1'b0;
            mpie_q  <= 1'b0;
            mpp_q   <= 2'd0;
            lr_q    <= 1'b0;
        end else begin
            lr_q <= trap_req && (dest_level != cur_priv);
            if (trap_req) begin
                priv_q  <= dest_level;
                pc_q    <= go_super ? vec_tgt[0] : vec_tgt[1];
                cause_q <= {req_intr, {PAD_W{1'b0}}, code};
                epc_q   <= cur_pc;
                tval_q  <= keeps_addr ? req_addr : '0;
                if (go_super) begin
                    spie_q <= cur_sie;
                    spp_q  <= (cur_priv == LVL_SUPER);
                    sie_q  <= 1'b0;
                    mie_q  <= cur_mie;
                    mpie_q <= cur_mpie;
                    mpp_q  <= cur_mpp;
                end else begin
                    mpie_q <= cur_mie;
                    mpp_q  <= cur_priv;
                    mie_q  <= 1'b0;
                    sie_q  <= cur_sie;
                    spie_q <= cur_spie;
                    spp_q  <= cur_spp;
                end
            end
        end
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            ST_ENTER_S: begin trap_valid = 1'b1; trap_to_m = 1'b0; end
            ST_ENTER_M: begin trap_valid = 1'b1; trap_to_m = 1'b1; end
            default:    begin trap_valid = 1'b0; trap_to_m = 1'b0; end
        endcase
    end

    assign new_priv  = priv_q;
    assign new_pc    = pc_q;
    assign cause_out = cause_q;
    assign epc_out   = epc_q;
    assign tval_out  = tval_q;
    assign out_sie   = sie_q;
    assign out_spie  = spie_q;
    assign out_spp   = spp_q;
    assign out_mie   = mie_q;
    assign out_mpie  = mpie_q;
    assign out_mpp   = mpp_q;
    assign lr_clear  = lr_q;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic            req_intr,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] cur_pc,
    input logic            trap_valid,
    input logic            trap_to_m,
    input logic [1:0]      new_priv,
    input logic [XLEN-1:0] epc_out,
    input logic [XLEN-1:0] cause_out,
    input logic [XLEN-1:0] tval_out,
    input logic            out_sie,
    input logic            out_mie,
    input logic            lr_clear
);

    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> trap_valid); // R1
    AST_NO_REQ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> !trap_valid); // R1
    AST_MACH_KEEPS_MACH: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_priv == 2'd3) |=> trap_to_m); // R2
    AST_SUPER_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_to_m) |-> (!out_sie && new_priv == 2'd1)); // R3
    AST_MACH_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_to_m) |-> (!out_mie && new_priv == 2'd3)); // R4
    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (epc_out == $past(cur_pc))); // R5
    AST_INTR_FLAG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (cause_out[XLEN-1] == $past(req_intr))); // R5
    AST_INTR_NO_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && req_intr) |=> (tval_out == '0)); // R6
    AST_LR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        lr_clear |-> trap_valid); // R12

endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_req   (trap_req),
    .req_intr   (req_intr),
    .cur_priv   (cur_priv),
    .cur_pc     (cur_pc),
    .trap_valid (trap_valid),
    .trap_to_m  (trap_to_m),
    .new_priv   (new_priv),
    .epc_out    (epc_out),
    .cause_out  (cause_out),
    .tval_out   (tval_out),
    .out_sie    (out_sie),
    .out_mie    (out_mie),
    .lr_clear   (lr_clear)
);

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb_top;

    localparam int XLEN    = 32;
    localparam int CAUSE_W = 6;
    localparam logic [31:0] PC_FIX   = 32'h1000_0040;
    localparam logic [31:0] ADDR_FIX = 32'hDEAD_BEE0;
    localparam logic [31:0] MBASE    = 32'h8000_0100;
    localparam logic [31:0] SBASE    = 32'h4000_0200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              trap_req = 0, req_intr = 0, req_prot_fail = 0, xlate_on = 0;
    logic [1:0]        req_src = 0, req_acc = 0, cur_priv = 0, cur_mpp = 0;
    logic [5:0]        req_cause = 0;
    logic [31:0]       req_addr = ADDR_FIX, cur_pc = PC_FIX;
    logic              cur_sie = 1, cur_spie = 0, cur_spp = 0, cur_mie = 1, cur_mpie = 0;
    logic [31:0]       ideleg = 32'h0000_0222, edeleg = 32'h0000_2124;
    logic [31:0]       stvec = 32'h4000_0200, mtvec = 32'h8000_0101;
    logic              trap_valid, trap_to_m, out_sie, out_spie, out_spp, out_mie, out_mpie, lr_clear;
    logic [1:0]        new_priv, out_mpp;
    logic [31:0]       new_pc, cause_out, epc_out, tval_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .req_intr(req_intr),
        .req_src(req_src), .req_acc(req_acc), .req_prot_fail(req_prot_fail),
        .xlate_on(xlate_on), .req_cause(req_cause), .req_addr(req_addr),
        .cur_pc(cur_pc), .cur_priv(cur_priv), .cur_sie(cur_sie), .cur_spie(cur_spie),
        .cur_spp(cur_spp), .cur_mie(cur_mie), .cur_mpie(cur_mpie), .cur_mpp(cur_mpp),
        .ideleg(ideleg), .edeleg(edeleg), .stvec(stvec), .mtvec(mtvec),
        .trap_valid(trap_valid), .trap_to_m(trap_to_m), .new_priv(new_priv),
        .new_pc(new_pc), .cause_out(cause_out), .epc_out(epc_out), .tval_out(tval_out),
        .out_sie(out_sie), .out_spie(out_spie), .out_spp(out_spp), .out_mie(out_mie),
        .out_mpie(out_mpie), .out_mpp(out_mpp), .lr_clear(lr_clear)
    );

    typedef struct packed {
        logic       intr;
        logic [1:0] src;
        logic [1:0] acc;
        logic       prot;
        logic       xon;
        logic [5:0] cin;
        logic [1:0] priv;
        logic [5:0] ecause;
        logic       etom;
        logic       etval;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 6'd5,  2'd0, 6'd5,  1'b0, 1'b0}, // R2 intr deleg U
        '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 6'd7,  2'd1, 6'd7,  1'b1, 1'b0}, // R8 vectored
        '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 6'd5,  2'd3, 6'd5,  1'b1, 1'b0}, // R2 from M
        '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 6'd2,  2'd0, 6'd2,  1'b0, 1'b0}, // R2 exc deleg
        '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 6'd8,  2'd0, 6'd8,  1'b0, 1'b0}, // R7 ecall U
        '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 6'd8,  2'd1, 6'd9,  1'b1, 1'b0}, // R7 ecall S
        '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 6'd8,  2'd3, 6'd11, 1'b1, 1'b0}, // R7 ecall M
        '{1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 6'd0,  2'd0, 6'd0,  1'b1, 1'b1}, // R9 fetch
        '{1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 6'd0,  2'd0, 6'd4,  1'b1, 1'b1}, // R9 load
        '{1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 6'd0,  2'd1, 6'd6,  1'b1, 1'b1}, // R9 store
        '{1'b0, 2'd2, 2'd1, 1'b0, 1'b1, 6'd0,  2'd1, 6'd13, 1'b0, 1'b1}, // R10 load PF
        '{1'b0, 2'd2, 2'd1, 1'b1, 1'b1, 6'd0,  2'd1, 6'd5,  1'b0, 1'b1}, // R10 prot
        '{1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 6'd0,  2'd0, 6'd1,  1'b1, 1'b1}, // R10 xlate off
        '{1'b0, 2'd2, 2'd2, 1'b0, 1'b1, 6'd0,  2'd0, 6'd15, 1'b1, 1'b1}, // R10 store PF
        '{1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 6'd0,  2'd1, 6'd12, 1'b1, 1'b1}, // R10 fetch PF
        '{1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 6'd0,  2'd0, 6'd7,  1'b1, 1'b1}, // R10 store prot
        '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 6'd3,  2'd0, 6'd3,  1'b1, 1'b0}, // R6 no addr
        '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 6'd9,  2'd1, 6'd9,  1'b0, 1'b0}, // R7 intr 9 kept
        '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 6'd13, 2'd3, 6'd13, 1'b1, 1'b1}, // R6 direct 13
        '{1'b1, 2'd2, 2'd1, 1'b0, 1'b1, 6'd1,  2'd0, 6'd1,  1'b0, 1'b0}, // R10 src ignored
        '{1'b0, 2'd1, 2'd3, 1'b0, 1'b0, 6'd0,  2'd0, 6'd6,  1'b1, 1'b1}  // R9 acc 3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fire(input logic intr, input logic [1:0] src, input logic [1:0] acc,
                        input logic prot, input logic xon, input logic [5:0] cin,
                        input logic [1:0] priv);
        req_intr = intr; req_src = src; req_acc = acc; req_prot_fail = prot;
        xlate_on = xon; req_cause = cin; cur_priv = priv; trap_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_bad++;
            n_cmp++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset values
        chk("R11 valid", {31'b0, trap_valid}, 0);
        chk("R11 lr", {31'b0, lr_clear}, 0);
        chk("R11 priv", {30'b0, new_priv}, 3);
        chk("R11 pc", new_pc, 0);
        chk("R11 cause", cause_out, 0);
        chk("R11 tval", tval_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 valid after", {31'b0, trap_valid}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [1:0]  ep;
            logic [31:0] epc;
            v = TBL[i];
            fire(v.intr, v.src, v.acc, v.prot, v.xon, v.cin, v.priv);
            ep  = v.etom ? 2'd3 : 2'd1;
            epc = v.etom ? (v.intr ? MBASE + {24'b0, v.ecause, 2'b0} : MBASE) : SBASE;
            chk("R1 valid", {31'b0, trap_valid}, 1);
            chk("R2 to_m", {31'b0, trap_to_m}, {31'b0, v.etom});
            chk("R5 cause", cause_out, {v.intr, 25'b0, v.ecause});
            chk("R5 epc", epc_out, PC_FIX);
            chk("R6 tval", tval_out, v.etval ? ADDR_FIX : 32'h0);
            chk("R8 pc", new_pc, epc);
            chk("R12 lr", {31'b0, lr_clear}, {31'b0, ep != v.priv});
            if (v.etom) begin
                chk("R4 priv", {30'b0, new_priv}, 3);
                chk("R4 mpie", {31'b0, out_mpie}, 1);
                chk("R4 mpp", {30'b0, out_mpp}, {30'b0, v.priv});
                chk("R4 mie", {31'b0, out_mie}, 0);
                chk("R4 s pass", {29'b0, out_sie, out_spie, out_spp}, 32'h4);
            end else begin
                chk("R3 priv", {30'b0, new_priv}, 1);
                chk("R3 spie", {31'b0, out_spie}, 1);
                chk("R3 spp", {31'b0, out_spp}, {31'b0, v.priv == 2'd1});
                chk("R3 sie", {31'b0, out_sie}, 0);
                chk("R3 m pass", {28'b0, out_mie, out_mpie, out_mpp}, 32'h8);
            end
        end
        trap_req = 1'b0;
        @(negedge clk);
        chk("R1 idle", {31'b0, trap_valid}, 0);
        chk("R12 idle lr", {31'b0, lr_clear}, 0);

        // R2 cause beyond mask width
        ideleg = 32'hFFFF_FFFF;
        fire(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 6'd40, 2'd0);
        chk("R2 cause 40", {31'b0, trap_to_m}, 1);
        chk("R8 pc 40", new_pc, MBASE + 32'd160);
        ideleg = 32'h0000_0222;

        // R8 supervisor vectored
        stvec = 32'h4000_0201;
        fire(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 6'd5, 2'd0);
        chk("R8 s vectored", new_pc, SBASE + 32'd20);
        // R8 vectored but exception: no offset
        fire(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 6'd2, 2'd0);
        chk("R8 s exc", new_pc, SBASE);
        stvec = 32'h4000_0200;

        // R8 mode 3 adds nothing
        mtvec = 32'h8000_0103;
        fire(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 6'd7, 2'd0);
        chk("R8 mode3", new_pc, MBASE);
        mtvec = 32'h8000_0102;
        fire(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 6'd7, 2'd0);
        chk("R8 mode2", new_pc, MBASE);
        mtvec = 32'h8000_0101;

        // R3 status with enables inverted, S to S
        cur_sie = 0; cur_spie = 1; cur_mie = 0; cur_mpie = 1; cur_mpp = 2'd3; cur_spp = 1;
        fire(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 6'd5, 2'd1);
        chk("R3 spie zero", {31'b0, out_spie}, 0);
        chk("R3 spp S", {31'b0, out_spp}, 1);
        chk("R3 m pass2", {28'b0, out_mie, out_mpie, out_mpp}, 32'h7);
        chk("R12 same priv", {31'b0, lr_clear}, 0);

        // R4 reserved level 2 goes to M even when delegated
        fire(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 6'd2, 2'd2);
        chk("R4 lvl2 to_m", {31'b0, trap_to_m}, 1);
        chk("R4 lvl2 mpp", {30'b0, out_mpp}, 2);
        chk("R4 mpie from mie", {31'b0, out_mpie}, 0);
        chk("R4 s pass2", {29'b0, out_sie, out_spie, out_spp}, 32'h3);
        chk("R12 lvl2 lr", {31'b0, lr_clear}, 1);
        trap_req = 1'b0;
        @(negedge clk);
        chk("R1 end idle", {31'b0, trap_valid}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule